// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave With Address-Pointer Reads

This block is a byte-wide memory that answers as a slave on a two-wire clock/data bus. It has a 256-byte storage array and an internal address pointer. The pointer survives from one transaction to the next. Bus traffic is sampled in the system clock domain. The block drives the data line only through an open-drain style enable (`sda_oe` high pulls the line low).

Three kinds of read are supported:
- A random read. The master first writes a word address, then issues a repeated start and switches to read.
- A current-address read. The master goes straight to read, and the block returns the byte at the pointer.
- A sequential read, which extends either of the two. Every master acknowledge after a byte advances the pointer and shifts out the next byte.

A single-byte write is also accepted, so that contents can be preloaded.

The controller is one state machine. Its states are:
- `S_IDLE`: ignores the bus until a start condition.
- `S_DEVADDR`: shifts in the device byte.
- `S_DEVACK`: acknowledges the device byte.
- `S_WADDR`: shifts in the word address.
- `S_WAACK`: acknowledges the word address.
- `S_WDATA`: shifts in the write byte.
- `S_WDACK`: acknowledges the write byte.
- `S_RDATA`: shifts a byte out.
- `S_MACK`: samples the master's acknowledge.

The transitions are:
- A stop sends any state to `S_IDLE`. A start sends any state to `S_DEVADDR`.
- `S_DEVADDR` goes to `S_DEVACK` on a device match and to `S_IDLE` on a mismatch.
- `S_DEVACK` goes to `S_RDATA` on a read and to `S_WADDR` on a write.
- The write path runs `S_WADDR` to `S_WAACK`, then `S_WDATA`, then `S_WDACK`, then `S_IDLE`.
- The read path runs `S_RDATA` to `S_MACK`. From `S_MACK` it returns to `S_RDATA` on a master acknowledge and goes to `S_IDLE` on a master not-acknowledge.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, `sda_oe` is low and the address pointer is 0. A reset in the middle of a read releases SDA at once. The array contents are not cleared by reset.
- R2: The block acknowledges (drives SDA low in the ninth bit) only a device byte equal to `1010`, then `dev_sel[2:0]`, then the direction bit, MSB first. A direction bit of 1 means read. On any other byte it gives no acknowledge and drives nothing until the next start.
- R3: A write (device byte with direction 0, word address, one data byte, each acknowledged, then stop) stores the data at the word address and leaves the pointer at word address + 1.
- R4: A random read (device byte for write, word address, repeated start, device byte for read) returns the byte at that word address, MSB first.
- R5: A current-address read returns the byte at the pointer, which is one past the last byte read, including the last byte of a sequential read.
- R6: A master acknowledge (SDA low in the ninth bit) after a read byte makes the block send the byte at the next address.
- R7: The pointer wraps from 0xFF to 0x00, both within a sequential read and between transactions.
- R8: After a master not-acknowledge the block releases SDA and drives nothing further until the next start. A stop returns it to idle with SDA released.
- R9: A start or stop anywhere aborts the transfer in progress. A write cut short before its eighth data bit stores nothing. A word address cut short before its eighth bit leaves the pointer unchanged.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| dev_sel | input | 3 | Low three bits of the device byte this slave answers to |
| sda_oe | output | 1 | High pulls the data line low; low leaves it released |

## Verification
SCL passes through two synchroniser flops and one edge register, so `sda_oe` moves on the third system clock after an SCL fall. Every acknowledge and data bit is therefore settled several cycles before the next SCL rise. The bench holds each SCL phase for 12 system clocks and samples SDA in the middle of the high phase, well clear of that three-cycle lag. It reads ports a nanosecond after the rising edge. Abort and pointer effects only become visible in the next transaction, so they are checked by the bytes that a following current-address read returns.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVADDR,
        S_DEVACK,
        S_WADDR,
        S_WAACK,
        S_WDATA,
        S_WDACK,
        S_RDATA,
        S_MACK
    } twm_state_e;

endpackage

// File: rtl/twm_bus_sync.sv
module twm_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_ff;
    logic [LAST:0] sda_ff;
    logic          scl_d;
    logic          sda_d;
    logic          scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[LAST-1:0], scl_i};
            sda_ff <= {sda_ff[LAST-1:0], sda_i};
            scl_d  <= scl_ff[LAST];
            sda_d  <= sda_ff[LAST];
        end
    end

    assign scl_s     = scl_ff[LAST];
    assign sda_s     = sda_ff[LAST];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twm_store.sv
module twm_store #(
    parameter int AW = 8
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [AW-1:0]                waddr,
    input  logic [twm_pkg::BYTE_W-1:0]   wdata,
    input  logic [AW-1:0]                raddr,
    output logic [twm_pkg::BYTE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << AW;

    logic [twm_pkg::BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
    import twm_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [2:0]        dev_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              we,
    output logic [AW-1:0]     waddr,
    output logic [BYTE_W-1:0] wdata,
    output logic [AW-1:0]     ptr,
    output logic              sda_oe,
    output twm_state_e        state
);
    localparam int CW = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

    twm_state_e        state_q, state_n;
    logic [CW-1:0]     cnt_q, cnt_n;
    logic [BYTE_W-1:0] sh_q, sh_n;
    logic [AW-1:0]     ptr_q, ptr_n;
    logic              rw_q, rw_n;
    logic              more_q, more_n;
    logic              oe_q, oe_n;
    logic              ph_q, ph_n;
    logic [BYTE_W-1:0] shin;
    logic              last;

    assign shin = {sh_q[BYTE_W-2:0], sda_s};
    assign last = (cnt_q == LAST_BIT);

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        sh_n    = sh_q;
        ptr_n   = ptr_q;
        rw_n    = rw_q;
        more_n  = more_q;
        oe_n    = oe_q;
        ph_n    = ph_q;
        we      = 1'b0;
        wdata   = shin;
        if (stop_evt) begin
            state_n = S_IDLE;
            oe_n    = 1'b0;
            ph_n    = 1'b0;
        end else if (start_evt) begin
            state_n = S_DEVADDR;
            cnt_n   = '0;
            oe_n    = 1'b0;
            ph_n    = 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: ;
                S_DEVADDR: begin
                    if (scl_rise) begin
                        sh_n  = shin;
                        cnt_n = cnt_q + CW'(1);
                        if (last) begin
                            if (shin[BYTE_W-1:1] == {DEV_CODE, dev_sel}) begin
                                rw_n    = shin[0];
                                state_n = S_DEVACK;
                            end else begin
                                state_n = S_IDLE;
                            end
                        end
                    end
                end
                S_DEVACK, S_WAACK, S_WDACK: begin
                    if (scl_fall) begin
                        if (!ph_q) begin
                            oe_n = 1'b1;
                            ph_n = 1'b1;
                        end else begin
                            ph_n  = 1'b0;
                            oe_n  = 1'b0;
                            cnt_n = '0;
                            if (state_q == S_DEVACK) begin
                                if (rw_q) begin
                                    state_n = S_RDATA;
                                    sh_n    = rd_data;
                                    oe_n    = ~rd_data[BYTE_W-1];
                                end else begin
                                    state_n = S_WADDR;
                                end
                            end else if (state_q == S_WAACK) begin
                                state_n = S_WDATA;
                            end else begin
                                state_n = S_IDLE;
                            end
                        end
                    end
                end
                S_WADDR: begin
                    if (scl_rise) begin
                        sh_n  = shin;
                        cnt_n = cnt_q + CW'(1);
                        if (last) begin
                            ptr_n   = shin[AW-1:0];
                            state_n = S_WAACK;
                        end
                    end
                end
                S_WDATA: begin
                    if (scl_rise) begin
                        sh_n  = shin;
                        cnt_n = cnt_q + CW'(1);
                        if (last) begin
                            we      = 1'b1;
                            ptr_n   = ptr_q + AW'(1);
                            state_n = S_WDACK;
                        end
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        if (last) begin
                            oe_n    = 1'b0;
                            state_n = S_MACK;
                        end else begin
                            cnt_n = cnt_q + CW'(1);
                            sh_n  = {sh_q[BYTE_W-2:0], sh_q[BYTE_W-1]};
                            oe_n  = ~sh_q[BYTE_W-2];
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        more_n = ~sda_s;
                        ptr_n  = ptr_q + AW'(1);
                    end else if (scl_fall) begin
                        if (more_q) begin
                            state_n = S_RDATA;
                            cnt_n   = '0;
                            sh_n    = rd_data;
                            oe_n    = ~rd_data[BYTE_W-1];
                        end else begin
                            state_n = S_IDLE;
                        end
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            ptr_q  <= '0;
            rw_q   <= 1'b0;
            more_q <= 1'b0;
            oe_q   <= 1'b0;
            ph_q   <= 1'b0;
        end else begin
            cnt_q  <= cnt_n;
            sh_q   <= sh_n;
            ptr_q  <= ptr_n;
            rw_q   <= rw_n;
            more_q <= more_n;
            oe_q   <= oe_n;
            ph_q   <= ph_n;
        end
    end

    assign waddr  = ptr_q;
    assign ptr    = ptr_q;
    assign sda_oe = oe_q;
    assign state  = state_q;

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel,
    output logic       sda_oe
);
    import twm_pkg::*;

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic              we;
    logic [AW-1:0]     waddr;
    logic [BYTE_W-1:0] wdata;
    logic [AW-1:0]     ptr;
    logic [BYTE_W-1:0] rd_data;
    twm_state_e        state;

    twm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    twm_store #(.AW(AW)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (ptr),
        .rdata (rd_data)
    );

    twm_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .dev_sel   (dev_sel),
        .rd_data   (rd_data),
        .we        (we),
        .waddr     (waddr),
        .wdata     (wdata),
        .ptr       (ptr),
        .sda_oe    (sda_oe),
        .state     (state)
    );

endmodule

// File: rtl/twm_checker.sv
module twm_checker
    import twm_pkg::*;
#(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_fall,
    input logic          start_evt,
    input logic          stop_evt,
    input logic          sda_oe,
    input twm_state_e    state,
    input logic [AW-1:0] ptr
);

    // R10: the line driver only moves right after an SCL fall (or an abort event)
    p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_evt || stop_evt));

    // R8: idle never drives the line
    p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);

    // R2: the line is driven only in acknowledge or read-out states
    p_drive_states_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state inside {S_DEVACK, S_WAACK, S_WDACK, S_RDATA}));

    // R6 / R7: outside a word-address load, the pointer only steps by one (mod 2^AW)
    p_ptr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr != $past(ptr)) && ($past(state) != S_WADDR)) |->
        (ptr == AW'($past(ptr) + AW'(1))));

endmodule

bind twi_mem_slave twm_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .sda_oe    (sda_oe),
    .state     (state),
    .ptr       (ptr)
);

// File: tb/tb_twi_mem_slave.sv
`timescale 1ns/1ps
module tb_twi_mem_slave;

    localparam int Q  = 12;
    localparam int WD = 150000;
    localparam int NV = 14;
    // {op[1:0], tag[3:0], addr[7:0], data[7:0]}; op 0 write, 1 random read, 2 current read
    localparam logic [21:0] VEC [NV] = '{
        {2'd0, 4'd3, 8'h10, 8'hA5},
        {2'd0, 4'd3, 8'h11, 8'h3C},
        {2'd0, 4'd3, 8'h12, 8'hC3},
        {2'd0, 4'd3, 8'h13, 8'h99},
        {2'd0, 4'd3, 8'hFF, 8'h81},
        {2'd0, 4'd3, 8'h01, 8'h5A},
        {2'd0, 4'd3, 8'h00, 8'h7E},
        {2'd2, 4'd3, 8'h00, 8'h5A},
        {2'd1, 4'd4, 8'h10, 8'hA5},
        {2'd2, 4'd5, 8'h00, 8'h3C},
        {2'd2, 4'd5, 8'h00, 8'hC3},
        {2'd1, 4'd4, 8'hFF, 8'h81},
        {2'd2, 4'd7, 8'h00, 8'h7E},
        {2'd2, 4'd5, 8'h00, 8'h5A}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] dev_sel = 3'b101;
    logic       sda_oe;
    logic       sda_bus;
    int         nchk = 0;
    int         nerr = 0;
    int         viol = 0;
    logic       oe_prev = 1'b0;

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    twi_mem_slave dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .dev_sel (dev_sel),
        .sda_oe  (sda_oe)
    );

    // R10 monitor at the ports
    always @(posedge clk) begin
        #1;
        if (rst_n && (sda_oe !== oe_prev) && scl_m) viol++;
        oe_prev = sda_oe;
    end

    function automatic string tag(input logic [3:0] n);
        case (n)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [7:0] dbyte(input logic [2:0] sel, input logic rd);
        return {4'b1010, sel, rd};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (Q) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b0; hold();
        scl_m = 1'b0; hold();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; hold();
        scl_m = 1'b1; hold();
        sda_m = 1'b1; hold();
    endtask

    task automatic tx_bit(input logic b);
        sda_m = b; hold();
        scl_m = 1'b1; hold();
        scl_m = 1'b0;
    endtask

    task automatic rx_bit(output logic b);
        sda_m = 1'b1; hold();
        scl_m = 1'b1;
        repeat (Q/2) @(negedge clk);
        b = sda_bus;
        repeat (Q/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic tx_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) tx_bit(v[i]);
        rx_bit(b);
        acked = ~b;
    endtask

    task automatic rx_byte(output logic [7:0] v, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rx_bit(b);
            v[i] = b;
        end
        tx_bit(~mack);
    endtask

    task automatic op_write(input logic [7:0] a, input logic [7:0] d);
        logic ak;
        m_start();
        tx_byte(dbyte(dev_sel, 1'b0), ak); check("R3 dev ack", {31'd0, ak}, 32'd1);
        tx_byte(a, ak);                    check("R3 addr ack", {31'd0, ak}, 32'd1);
        tx_byte(d, ak);                    check("R3 data ack", {31'd0, ak}, 32'd1);
        m_stop();
    endtask

    task automatic rd_begin(input logic rnd, input logic [7:0] a, input string req);
        logic ak;
        m_start();
        if (rnd) begin
            tx_byte(dbyte(dev_sel, 1'b0), ak); check({req, " wdev ack"}, {31'd0, ak}, 32'd1);
            tx_byte(a, ak);                    check({req, " addr ack"}, {31'd0, ak}, 32'd1);
            m_start();
        end
        tx_byte(dbyte(dev_sel, 1'b1), ak); check({req, " rdev ack"}, {31'd0, ak}, 32'd1);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       ak;
        logic       b;
        repeat (5) @(negedge clk);
        check("R1 oe in reset", {31'd0, sda_oe}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 oe after reset", {31'd0, sda_oe}, 32'd0);

        // vector table: writes, random reads, current reads
        for (int k = 0; k < NV; k++) begin
            case (VEC[k][21:20])
                2'd0: op_write(VEC[k][15:8], VEC[k][7:0]);
                2'd1: begin
                    rd_begin(1'b1, VEC[k][15:8], tag(VEC[k][19:16]));
                    rx_byte(v, 1'b0);
                    check(tag(VEC[k][19:16]), {24'd0, v}, {24'd0, VEC[k][7:0]});
                    m_stop();
                end
                default: begin
                    rd_begin(1'b0, 8'h00, tag(VEC[k][19:16]));
                    rx_byte(v, 1'b0);
                    check(tag(VEC[k][19:16]), {24'd0, v}, {24'd0, VEC[k][7:0]});
                    m_stop();
                end
            endcase
        end

        // R6: sequential read from 0x10, then R5 current read after it
        rd_begin(1'b1, 8'h10, "R6");
        rx_byte(v, 1'b1); check("R6 byte0", {24'd0, v}, 32'hA5);
        rx_byte(v, 1'b1); check("R6 byte1", {24'd0, v}, 32'h3C);
        rx_byte(v, 1'b0); check("R6 byte2", {24'd0, v}, 32'hC3);
        m_stop();
        rd_begin(1'b0, 8'h00, "R5");
        rx_byte(v, 1'b0); check("R5 after sequential", {24'd0, v}, 32'h99);
        m_stop();

        // R7: sequential read wrapping 0xFF -> 0x00
        rd_begin(1'b1, 8'hFF, "R7");
        rx_byte(v, 1'b1); check("R7 byte FF", {24'd0, v}, 32'h81);
        rx_byte(v, 1'b1); check("R7 byte 00", {24'd0, v}, 32'h7E);
        rx_byte(v, 1'b0); check("R7 byte 01", {24'd0, v}, 32'h5A);
        m_stop();

        // R2: wrong select bits, then wrong device code
        m_start();
        tx_byte(dbyte(3'b110, 1'b1), ak); check("R2 sel mismatch nack", {31'd0, ak}, 32'd0);
        rx_byte(v, 1'b0); check("R2 silent after mismatch", {24'd0, v}, 32'hFF);
        m_stop();
        m_start();
        tx_byte(8'b1011_1011, ak); check("R2 code mismatch nack", {31'd0, ak}, 32'd0);
        m_stop();

        // R9: write aborted mid-data by stop; word address 0x10 was loaded
        m_start();
        tx_byte(dbyte(dev_sel, 1'b0), ak); check("R9 dev ack", {31'd0, ak}, 32'd1);
        tx_byte(8'h10, ak);                check("R9 addr ack", {31'd0, ak}, 32'd1);
        for (int i = 0; i < 4; i++) tx_bit(1'b0);
        m_stop();
        rd_begin(1'b0, 8'h00, "R9");
        rx_byte(v, 1'b0); check("R9 no partial write", {24'd0, v}, 32'hA5);
        m_stop();

        // R9: word address cut by repeated start keeps pointer at 0x11
        m_start();
        tx_byte(dbyte(dev_sel, 1'b0), ak); check("R9 dev ack 2", {31'd0, ak}, 32'd1);
        for (int i = 0; i < 4; i++) tx_bit(1'b1);
        m_start();
        tx_byte(dbyte(dev_sel, 1'b1), ak); check("R9 rdev ack", {31'd0, ak}, 32'd1);
        rx_byte(v, 1'b0); check("R9 pointer kept", {24'd0, v}, 32'h3C);
        // R8: after NACK, no stop yet: slave stays silent
        rx_byte(v, 1'b0); check("R8 silent after nack", {24'd0, v}, 32'hFF);
        m_stop();
        check("R8 released after stop", {31'd0, sda_oe}, 32'd0);

        // R1: reset while driving bit7 (0) of 0x3C at address 0x11
        rd_begin(1'b1, 8'h11, "R4");
        repeat (4) @(negedge clk);
        check("R4 drives msb low", {31'd0, sda_oe}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset releases", {31'd0, sda_oe}, 32'd0);
        sda_m = 1'b1;
        scl_m = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd_begin(1'b0, 8'h00, "R1");
        rx_byte(v, 1'b0); check("R1 pointer zero after reset", {24'd0, v}, 32'h7E);
        m_stop();

        check("R10 oe changed with SCL high", viol, 32'd0);
        b = sda_oe;
        check("R8 idle end", {31'd0, b}, 32'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule